// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit buses, called A and B. It can pass data from one bus to the other, and it has one storage register for each direction. For each direction, a source select chooses whether the bus being driven carries the live data from the opposite bus or the value held in that direction's register.

An active-low enable gates all driving. A direction input then picks which bus receives data. With the enable high, both buses are isolated, but the two registers still load on their own strobes.

Each bus is modelled as three plain signals: an input, an output and an output-enable. This keeps the block synthesizable. Pad drivers are left to the chip level. The capture strobes are asynchronous to the system clock, so each one is synchronized and edge-detected before it loads a register. A polarity input inverts both output paths, for live and for stored data.

Top module: `dual_bus_xcvr`

## Requirements
- R1: While `rst` is high at a clock edge, both registers clear to 0 after that edge. Both output-enables are low during reset.
- R2: If `capA` is first sampled high at clock edge k, after being sampled low at edge k-1, the A register loads `aIn` as it stands at edge k+2.
- R3: If `capB` is first sampled high at clock edge k, after being sampled low at edge k-1, the B register loads `bIn` as it stands at edge k+2.
- R4: A strobe held high loads its register once only. Later changes on the bus leave the stored value alone until the strobe falls and rises again.
- R5: `bOut` equals `aIn` when `selStoredToB`=0 and equals the A register when `selStoredToB`=1, in both cases XOR with all ones when `invertOut`=1.
- R6: `aOut` equals `bIn` when `selStoredToA`=0 and equals the B register when `selStoredToA`=1, in both cases XOR with all ones when `invertOut`=1.
- R7: With `enN`=1, `aOe` and `bOe` are both 0. With `enN`=0, `dirToB`=1 gives `bOe`=1 and `aOe`=0, and `dirToB`=0 gives `aOe`=1 and `bOe`=0.
- R8: `aOe` and `bOe` are never high in the same cycle.
- R9: Both registers load normally while `enN`=1 (isolation).
- R10: Both registers can load on the same clock edge, each from its own bus. This works whichever bus is being driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enN | input | 1 | Active-low output enable |
| dirToB | input | 1 | 1: drive bus B, 0: drive bus A |
| capA | input | 1 | Capture strobe for the A register (asynchronous) |
| capB | input | 1 | Capture strobe for the B register (asynchronous) |
| selStoredToB | input | 1 | Bus B source: 0 live A, 1 stored A |
| selStoredToA | input | 1 | Bus A source: 0 live B, 1 stored B |
| invertOut | input | 1 | Static polarity: 1 inverts both outputs |
| aIn | input | 8 | Bus A input |
| aOut | output | 8 | Bus A output data |
| aOe | output | 1 | Bus A output-enable |
| bIn | input | 8 | Bus B input |
| bOut | output | 8 | Bus B output data |
| bOe | output | 1 | Bus B output-enable |

## Verification
A register can be loaded in the same cycle that its stored value is being sent to the opposite bus. The bench provokes this by driving bus B from the stored A register while it raises `capA`, and by changing `aIn` on every cycle of the strobe pipeline. The check is that `bOut` shows the old stored value up to edge k+2 and the `aIn` value from exactly that edge afterwards. A second sweep walks every combination of enable, direction, both selects and polarity, and compares each against arithmetic expectations.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef struct packed {
    logic loadA;
    logic loadB;
  } capStrobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       enN,
  input  logic       dirToB,
  input  logic       capA,
  input  logic       capB,
  output capStrobe_t caps,
  output logic       aOe,
  output logic       bOe
);
  localparam int CHANNELS = 2;

  logic [CHANNELS-1:0] rawStrobe;
  logic [CHANNELS-1:0] pulse;

  assign rawStrobe = {capB, capA};

  // per-channel synchronizer plus a history flop for edge detection
  for (genvar g = 0; g < CHANNELS; g++) begin : gSync
    logic [SYNC_STAGES:0] pipe;
    always_ff @(posedge clk) begin
      if (rst) pipe <= '0;
      else     pipe <= {pipe[SYNC_STAGES-1:0], rawStrobe[g]};
    end
    assign pulse[g] = pipe[SYNC_STAGES-1] & ~pipe[SYNC_STAGES];
  end

  always_comb begin
    caps.loadA = pulse[0];
    caps.loadB = pulse[1];
  end

  always_comb begin
    aOe = !rst && !enN && !dirToB;
    bOe = !rst && !enN && dirToB;
  end

  // R8: the two buses are never driven together
  assert_oe_exclusive_R8: assert property (@(posedge clk) !(aOe && bOe));
  // R7: isolation releases both buses
  assert_isolate_R7: assert property (@(posedge clk) disable iff (rst)
    enN |-> (!aOe && !bOe));
  // R4: a load strobe lasts a single cycle
  assert_single_load_a_R4: assert property (@(posedge clk) disable iff (rst)
    caps.loadA |=> !caps.loadA);
  assert_single_load_b_R4: assert property (@(posedge clk) disable iff (rst)
    caps.loadB |=> !caps.loadB);
endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  capStrobe_t       caps,
  input  logic             selStoredToB,
  input  logic             selStoredToA,
  input  logic             invertOut,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut
);
  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic [WIDTH-1:0] polMask;

  always_ff @(posedge clk) begin
    if (rst) begin
      regA <= '0;
      regB <= '0;
    end else begin
      if (caps.loadA) regA <= aIn;
      if (caps.loadB) regB <= bIn;
    end
  end

  assign polMask = {WIDTH{invertOut}};

  always_comb begin
    bOut = (selStoredToB ? regA : aIn) ^ polMask;
    aOut = (selStoredToA ? regB : bIn) ^ polMask;
  end

  // R1: reset clears storage
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (regA == '0 && regB == '0));
  // R2: A register takes the bus value on a load
  assert_load_a_R2: assert property (@(posedge clk) disable iff (rst)
    caps.loadA |=> (regA == $past(aIn)));
  // R3: B register takes the bus value on a load
  assert_load_b_R3: assert property (@(posedge clk) disable iff (rst)
    caps.loadB |=> (regB == $past(bIn)));
  // R4: no load, no change
  assert_hold_a_R4: assert property (@(posedge clk) disable iff (rst)
    !caps.loadA |=> $stable(regA));
  assert_hold_b_R4: assert property (@(posedge clk) disable iff (rst)
    !caps.loadB |=> $stable(regB));
endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enN,
  input  logic             dirToB,
  input  logic             capA,
  input  logic             capB,
  input  logic             selStoredToB,
  input  logic             selStoredToA,
  input  logic             invertOut,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);
  capStrobe_t caps;

  xcvr_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .enN(enN), .dirToB(dirToB),
    .capA(capA), .capB(capB), .caps(caps), .aOe(aOe), .bOe(bOe)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .caps(caps),
    .selStoredToB(selStoredToB), .selStoredToA(selStoredToA),
    .invertOut(invertOut), .aIn(aIn), .bIn(bIn),
    .aOut(aOut), .bOut(bOut)
  );
endmodule

// File: tb/dual_bus_xcvr_bench.sv
`timescale 1ns/1ps
module dual_bus_xcvr_bench;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst, enN, dirToB, capA, capB, selStoredToB, selStoredToA, invertOut;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic aOe, bOe;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [W-1:0] expA, expB;

  always #2 clk = ~clk;

  dual_bus_xcvr u_dual_bus_xcvr (
    .clk(clk), .rst(rst), .enN(enN), .dirToB(dirToB), .capA(capA), .capB(capB),
    .selStoredToB(selStoredToB), .selStoredToA(selStoredToA), .invertOut(invertOut),
    .aIn(aIn), .aOut(aOut), .aOe(aOe), .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // view both stored values through the stored-data paths, true polarity
  task automatic checkStored(input string req);
    selStoredToB = 1; selStoredToA = 1; invertOut = 0;
    #0.1;
    chk(req, {24'd0, bOut}, {24'd0, expA});
    chk(req, {24'd0, aOut}, {24'd0, expB});
  endtask

  // both strobes optionally together; data held through the whole pipeline
  task automatic capture(input bit doA, input bit doB, input logic [W-1:0] da,
                         input logic [W-1:0] db);
    aIn = da; bIn = db; capA = doA; capB = doB;
    tick(3);
    capA = 0; capB = 0;
    tick(3);
    if (doA) expA = da;
    if (doB) expB = db;
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1; enN = 0; dirToB = 1; capA = 0; capB = 0;
    selStoredToB = 1; selStoredToA = 1; invertOut = 0; aIn = 8'h5A; bIn = 8'hA5;
    expA = 0; expB = 0;
    @(negedge clk);
    chk("R1 oe during reset", {30'd0, aOe, bOe}, 0);
    tick(2);
    chk("R1 regA reset", {24'd0, bOut}, 0);
    chk("R1 regB reset", {24'd0, aOut}, 0);
    rst = 0;
    tick(1);

    // R2: exact capture edge while stored A is being sent to B
    enN = 0; dirToB = 1; selStoredToB = 1;
    capA = 1; aIn = 8'h11;        // sampled high at edge k
    tick(1); aIn = 8'h22;         // after k
    chk("R2 before k+2", {24'd0, bOut}, 0);
    tick(1); aIn = 8'h33;         // after k+1, value present at k+2
    chk("R2 still old before k+2", {24'd0, bOut}, 0);
    tick(1); aIn = 8'h44;         // after k+2
    chk("R2 captured at k+2", {24'd0, bOut}, 8'h33);
    // R4: strobe held high, bus keeps changing
    tick(3); aIn = 8'h55; tick(2);
    chk("R4 held strobe no reload", {24'd0, bOut}, 8'h33);
    capA = 0; tick(3);
    expA = 8'h33;

    // R3: exact capture edge for B while stored B drives A
    dirToB = 0; selStoredToA = 1;
    capB = 1; bIn = 8'h61;
    tick(1); bIn = 8'h62;
    tick(1); bIn = 8'h63;
    chk("R3 old before k+2", {24'd0, aOut}, 0);
    tick(1); bIn = 8'h64;
    chk("R3 captured at k+2", {24'd0, aOut}, 8'h63);
    tick(2);
    chk("R4 B held strobe no reload", {24'd0, aOut}, 8'h63);
    capB = 0; tick(3);
    expB = 8'h63;

    // R9: capture during isolation, both outputs released
    enN = 1;
    capture(1, 0, 8'hC3, 8'h00);
    chk("R9 oe off in isolation", {30'd0, aOe, bOe}, 0);
    checkStored("R9 isolation capture A");
    capture(0, 1, 8'h00, 8'h3C);
    checkStored("R9 isolation capture B");

    // R10: both registers on the same edge, with each direction driven
    enN = 0; dirToB = 1;
    capture(1, 1, 8'h81, 8'h18);
    checkStored("R10 dual capture driving B");
    dirToB = 0;
    capture(1, 1, 8'hE7, 8'h7E);
    checkStored("R10 dual capture driving A");

    // R5 R6 R7 R8: sweep every control combination with varied data
    for (int c = 0; c < 32; c++) begin
      for (int d = 0; d < 4; d++) begin
        logic [W-1:0] la, lb, mask, eb, ea;
        la = W'(c * 37 + d * 91 + 3);
        lb = W'(c * 53 + d * 29 + 7);
        {enN, dirToB, selStoredToB, selStoredToA, invertOut} = 5'(c);
        aIn = la; bIn = lb;
        #0.5;
        mask = {W{invertOut}};
        eb = (selStoredToB ? expA : la) ^ mask;
        ea = (selStoredToA ? expB : lb) ^ mask;
        chk("R5 bOut select/polarity", {24'd0, bOut}, {24'd0, eb});
        chk("R6 aOut select/polarity", {24'd0, aOut}, {24'd0, ea});
        chk("R7 oe decode", {30'd0, aOe, bOe},
            {30'd0, !enN && !dirToB, !enN && dirToB});
        chk("R8 oe exclusive", {31'd0, aOe & bOe}, 0);
      end
      tick(1);
    end

    // R1: reset again after activity
    rst = 1; tick(1);
    chk("R1 oe in reset", {30'd0, aOe, bOe}, 0);
    rst = 0; expA = 0; expB = 0;
    checkStored("R1 registers cleared");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule